// File: doc/BRIEF.md
# I2C Write-Only Channel Register Loader with Burst Pointer

This block is the write side of an I2C target that fills a bank of 32 converter channel registers. It watches the SCL and SDA lines of the bus and recognises its own 7-bit address, which is a fixed prefix plus two bits strapped on input pins. It acknowledges every byte it accepts and turns each completed data word into a one-cycle register write strobe. The strobe carries a channel index, a 2-bit destination-register select and a 14-bit value.

In normal framing, a controller sends a pointer byte that names the channel, followed by two data bytes. A pointer of 0xFF instead starts a burst. In a burst, successive byte pairs land on channels 0, 1, 2 and so on, up to channel 31, with no pointer byte in between. After channel 31 is written, the block goes back to normal framing. A STOP or a repeated START ends a burst at any point. The design has no read path.

Top module: `i2c_burst_loader`

## Requirements
- R1: An address byte equal to binary 10101, then addr_sel[1], then addr_sel[0], then a 0 write bit, is acknowledged. The block holds sda_oe high while SCL is high in the ninth clock of that byte.
- R2: An address byte that differs in any bit is not acknowledged. This includes a read request, where the last bit is 1. After such a byte, no later byte is acknowledged and no strobe is issued until the next START.
- R3: In normal framing, a pointer byte other than 0xFF selects channel pointer[4:0]. The next two data bytes produce exactly one strobe for that channel. Every pointer and data byte is acknowledged.
- R4: In the first data byte of a word, bits [7:6] give wr_reg. wr_data equals first-byte bits [5:0] followed by the 8 bits of the second byte, MSB first.
- R5: A pointer byte of 0xFF starts a burst with the channel set to 0. Each later byte pair writes the current channel, and the channel then advances by one.
- R6: The pair that writes channel 31 ends the burst. The next byte is treated as a pointer byte again.
- R7: A STOP ends a burst. A new transaction starts in normal framing.
- R8: A repeated START restarts byte framing at the address byte and ends any burst.
- R9: After reset, wr_stb and sda_oe are low. wr_stb is high for one clock per completed word. That clock falls within the acknowledge of the word's second data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| addr_sel | input | 2 | Pin-strapped low address bits |
| sda_oe | output | 1 | Drive SDA low when high (acknowledge) |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_chan | output | 5 | Channel index of the write |
| wr_reg | output | 2 | Destination-register select |
| wr_data | output | 14 | Value to write |

## Verification
Single-channel writes with different pointers, and two back-to-back words in one transaction, check the pointer decode and the split of the data bytes into fields. Word values that vary per channel make a swapped or shifted field stand out. A full 32-channel burst followed by a pointer byte shows both the channel stepping and the return to pointer framing. A burst cut short by a STOP, and another cut short by a repeated START, show that the burst state is cleared: a later byte is read as a pointer and not as burst data. Wrong addresses, a read request and a second strap setting separate correct address matching from a block that acknowledges everything.

// File: rtl/i2c_burst_loader.sv
module i2c_burst_loader #(
  parameter int CHANS = 32,
  parameter int DW = 14,
  parameter logic [4:0] DEV_PREFIX = 5'b10101,
  parameter logic [7:0] BURST_PTR = 8'hFF,
  localparam int CW = $clog2(CHANS),
  localparam int HB = DW - 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [1:0]    addr_sel,
  output logic          sda_oe,
  output logic          wr_stb,
  output logic [CW-1:0] wr_chan,
  output logic [1:0]    wr_reg,
  output logic [DW-1:0] wr_data
);
  typedef enum logic [2:0] {P_IDLE, P_ADDR, P_PTR, P_MSB, P_LSB} phase_t;

  localparam logic [CW-1:0] LAST = CW'(CHANS - 1);

  logic [1:0] scl_q, sda_q;
  logic       scl_p, sda_p;
  phase_t     phase;
  logic [3:0] bcnt;
  logic       in_ack, burst;
  logic [7:0] sh, hi;
  logic [CW-1:0] chan;

  wire scl_s = scl_q[1];
  wire sda_s = sda_q[1];
  wire start = scl_s & scl_p & sda_p & ~sda_s;
  wire stop  = scl_s & scl_p & ~sda_p & sda_s;
  wire scl_rise = scl_s & ~scl_p;
  wire scl_fall = ~scl_s & scl_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 2'b11;
      sda_q <= 2'b11;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl_i};
      sda_q <= {sda_q[0], sda_i};
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= P_IDLE;
      bcnt    <= '0;
      in_ack  <= 1'b0;
      burst   <= 1'b0;
      sh      <= '0;
      hi      <= '0;
      chan    <= '0;
      sda_oe  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_chan <= '0;
      wr_reg  <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start || stop) begin
        phase  <= start ? P_ADDR : P_IDLE;
        bcnt   <= '0;
        in_ack <= 1'b0;
        burst  <= 1'b0;
        sda_oe <= 1'b0;
      end else if (phase != P_IDLE) begin
        if (scl_rise && bcnt < 4'd8) begin
          sh   <= {sh[6:0], sda_s};
          bcnt <= bcnt + 4'd1;
        end
        if (scl_fall) begin
          if (in_ack) begin
            in_ack <= 1'b0;
            sda_oe <= 1'b0;
            bcnt   <= '0;
          end else if (bcnt == 4'd8) begin
            in_ack <= 1'b1;
            sda_oe <= 1'b1;
            case (phase)
              P_ADDR: begin
                if (sh == {DEV_PREFIX, addr_sel, 1'b0}) phase <= P_PTR;
                else begin
                  sda_oe <= 1'b0;
                  phase  <= P_IDLE;
                end
              end
              P_PTR: begin
                burst <= (sh == BURST_PTR);
                chan  <= (sh == BURST_PTR) ? '0 : sh[CW-1:0];
                phase <= P_MSB;
              end
              P_MSB: begin
                hi    <= sh;
                phase <= P_LSB;
              end
              P_LSB: begin
                wr_stb  <= 1'b1;
                wr_chan <= chan;
                wr_reg  <= hi[7:6];
                wr_data <= {hi[HB-1:0], sh};
                if (burst && chan != LAST) begin
                  chan  <= chan + 1'b1;
                  phase <= P_MSB;
                end else begin
                  burst <= 1'b0;
                  phase <= P_PTR;
                end
              end
              default: phase <= P_IDLE;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_burst_loader_chk.sv
module i2c_burst_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe,
  input logic wr_stb
);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  a_r9_strobe_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> sda_oe);

  a_r1_ack_starts_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  a_r1_ack_stable_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe));
endmodule

bind i2c_burst_loader i2c_burst_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .wr_stb(wr_stb)
);

// File: tb/tb_i2c_burst_loader.sv
module tb_i2c_burst_loader;
  localparam int Q = 5;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic [1:0] addr_sel = 2'b01;
  logic sda_oe, wr_stb;
  logic [4:0] wr_chan;
  logic [1:0] wr_reg;
  logic [13:0] wr_data;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, failures = 0, n_stb = 0;
  logic [4:0]  lc [0:63];
  logic [15:0] lw [0:63];
  bit done = 1'b0;

  always #10 clk = ~clk;

  i2c_burst_loader dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .addr_sel(addr_sel),
    .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_chan(wr_chan), .wr_reg(wr_reg), .wr_data(wr_data)
  );

  always @(negedge clk) if (rst_n && wr_stb) begin
    if (n_stb < 64) begin
      lc[n_stb] = wr_chan;
      lw[n_stb] = {wr_reg, wr_data};
    end
    n_stb++;
  end

  task automatic w(int n); repeat (n) @(posedge clk); endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic start_c();
    scl = 0; w(Q); sda_m = 1; w(Q); scl = 1; w(2*Q); sda_m = 0; w(2*Q); scl = 0;
  endtask

  task automatic stop_c();
    scl = 0; w(Q); sda_m = 0; w(Q); scl = 1; w(2*Q); sda_m = 1; w(2*Q);
  endtask

  task automatic sb(input logic [7:0] v, input bit exp_ack, input string tag);
    bit ack;
    for (int i = 7; i >= 0; i--) begin
      scl = 0; w(Q); sda_m = v[i]; w(Q); scl = 1; w(2*Q);
    end
    scl = 0; w(Q); sda_m = 1; w(Q); scl = 1; w(Q); ack = !sda_line; w(Q); scl = 0;
    chk(ack == exp_ack, tag, int'(ack), int'(exp_ack));
  endtask

  task automatic word(input logic [15:0] d, input string tag);
    sb(d[15:8], 1'b1, tag);
    sb(d[7:0], 1'b1, tag);
  endtask

  task automatic chk_stb(int idx, logic [4:0] c, logic [15:0] d, string tag);
    chk(lc[idx] == c, tag, int'(lc[idx]), int'(c));
    chk(lw[idx] == d, tag, int'(lw[idx]), int'(d));
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R9 reset sda_oe", int'(sda_oe), 0);
    chk(wr_stb == 1'b0, "R9 reset wr_stb", int'(wr_stb), 0);
  endtask

  task automatic t_normal();
    int b = n_stb;
    start_c();
    sb(8'hAA, 1'b1, "R1 address ack");
    sb(8'h05, 1'b1, "R3 pointer ack");
    word(16'h9234, "R3 data ack");
    sb(8'h27, 1'b1, "R3 second pointer ack");
    word(16'h4ABC, "R4 data ack");
    stop_c(); w(4);
    chk(n_stb == b + 2, "R3 strobe count", n_stb - b, 2);
    chk_stb(b, 5'd5, 16'h9234, "R4 word fields ch5");
    chk_stb(b + 1, 5'd7, 16'h4ABC, "R3 pointer low bits ch7");
  endtask

  task automatic t_burst_full();
    int b = n_stb;
    start_c();
    sb(8'hAA, 1'b1, "R5 address");
    sb(8'hFF, 1'b1, "R5 burst pointer");
    for (int i = 0; i < 32; i++) word({2'(i % 4), 14'(i * 311 + 7)}, "R5 burst data ack");
    sb(8'h03, 1'b1, "R6 pointer after burst");
    word(16'hC001, "R6 data ack");
    stop_c(); w(4);
    chk(n_stb == b + 33, "R5 burst strobe count", n_stb - b, 33);
    for (int i = 0; i < 32; i++) chk_stb(b + i, 5'(i), {2'(i % 4), 14'(i * 311 + 7)}, "R5 burst channel");
    chk_stb(b + 32, 5'd3, 16'hC001, "R6 back to pointer framing");
  endtask

  task automatic t_burst_stop();
    int b = n_stb;
    start_c(); sb(8'hAA, 1'b1, "R7 address"); sb(8'hFF, 1'b1, "R7 burst ptr");
    word(16'h0111, "R7 w0"); word(16'h0222, "R7 w1"); word(16'h0333, "R7 w2");
    stop_c();
    start_c(); sb(8'hAA, 1'b1, "R7 address2");
    sb(8'h0A, 1'b1, "R7 pointer"); word(16'h5555, "R7 data");
    stop_c(); w(4);
    chk(n_stb == b + 4, "R7 strobe count", n_stb - b, 4);
    chk_stb(b + 2, 5'd2, 16'h0333, "R7 burst ch2");
    chk_stb(b + 3, 5'd10, 16'h5555, "R7 normal after stop");
  endtask

  task automatic t_rstart();
    int b = n_stb;
    start_c(); sb(8'hAA, 1'b1, "R8 address"); sb(8'hFF, 1'b1, "R8 burst ptr");
    word(16'h1001, "R8 w0"); word(16'h2002, "R8 w1");
    sb(8'h77, 1'b1, "R8 partial word byte");
    start_c(); sb(8'hAA, 1'b1, "R8 address after rstart");
    sb(8'h04, 1'b1, "R8 pointer"); word(16'h3003, "R8 data");
    stop_c(); w(4);
    chk(n_stb == b + 3, "R8 strobe count", n_stb - b, 3);
    chk_stb(b + 1, 5'd1, 16'h2002, "R8 burst ch1");
    chk_stb(b + 2, 5'd4, 16'h3003, "R8 framing reset");
  endtask

  task automatic t_mismatch();
    int b = n_stb;
    start_c();
    sb(8'hA8, 1'b0, "R2 wrong strap no ack");
    sb(8'h02, 1'b0, "R2 ignored byte");
    sb(8'h12, 1'b0, "R2 ignored byte");
    sb(8'h34, 1'b0, "R2 ignored byte");
    stop_c();
    start_c(); sb(8'hAB, 1'b0, "R2 read no ack"); sb(8'h01, 1'b0, "R2 ignored after read"); stop_c();
    start_c(); sb(8'h2A, 1'b0, "R2 wrong prefix no ack"); stop_c(); w(4);
    chk(n_stb == b, "R2 no strobe", n_stb - b, 0);
    addr_sel = 2'b11;
    start_c(); sb(8'hAA, 1'b0, "R1 old strap rejected"); stop_c();
    start_c(); sb(8'hAE, 1'b1, "R1 strap 11 ack");
    sb(8'h1F, 1'b1, "R1 pointer"); word(16'h3FFF, "R1 data");
    stop_c(); w(4);
    chk(n_stb == b + 1, "R1 strobe count", n_stb - b, 1);
    chk_stb(b, 5'd31, 16'h3FFF, "R4 max fields ch31");
  endtask

  initial begin
    w(3); rst_n = 1'b1; w(3);
    t_reset();
    t_normal();
    t_burst_full();
    t_burst_stop();
    t_rstart();
    t_mismatch();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    w(150000);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule